// File: doc/BRIEF.md
# Two-Trit Ternary Arithmetic Logic Unit

This block computes one of nine ternary operations on two 2-trit operands. Every trit travels on a 2-bit bus: `2'b00` is 0, `2'b01` is 1, `2'b10` is 2, and `2'b11` is illegal. An operand word `{t1, t0}` holds its high trit in bits [3:2], so its value is 3·t1 + t0 (0 to 8). A 2-trit select code `{s1, s0}` chooses the operation. The block returns a 2-trit primary result and, depending on the operation, a carry or borrow trit, two high product trits or three comparison flags.

Decoding follows a fixed order of states. The select code maps to an operation. The operands are then routed only to the unit that operation needs: the shared adder–subtractor, the multiplier or the comparator. The trit-wise logic functions are computed beside those units. A final multiplexer assembles the outputs. The path is combinational by default. When the parameter `REG_OUT` is set, a register stage with an asynchronous active-low reset captures every output on the rising clock edge.

Top module: `tern_alu`

## Requirements
- R1: The select code (s1 in bits [3:2], s0 in bits [1:0]) decodes as follows: 00 add, 01 subtract, 02 multiply, 10 compare, 11 NAND, 12 NOR, 20 XOR, 21 AND, 22 OR. No output trit ever carries `2'b11`.
- R2: Add gives res = (X+Y) mod 9 and carry trit = (X+Y) div 9 (0 or 1).
- R3: Subtract gives res = (X−Y) mod 9. Its carry trit is a borrow: 1 when X < Y, 0 otherwise.
- R4: Multiply gives res = (X·Y) mod 9 and high product word = (X·Y) div 9, with the same trit layout as the operands.
- R5: Compare drives lt, eq and gt, each 2 when true and 0 when false. Exactly one of them is 2, and res is 0.
- R6: AND gives the per-trit minimum and OR gives the per-trit maximum.
- R7: NAND gives per-trit 2 − min(a,b) and NOR gives per-trit 2 − max(a,b).
- R8: XOR gives per-trit (a+b) mod 3.
- R9: Outputs that an operation does not produce are 0. This covers carry, high product and flags outside their own operations, and res for compare.
- R10: If any trit of X, Y or the select code is `2'b11`, err is 1 and every other output is 0. Otherwise err is 0.
- R11: With `REG_OUT` = 1, the outputs show the combinational result one rising clock edge after the inputs are applied. While rst_n is low they are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checker |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_i | input | 2*N | Operand X, high trit in the upper pair |
| y_i | input | 2*N | Operand Y, same layout |
| sel_i | input | 4 | Operation select code {s1, s0} |
| res_o | output | 2*N | Primary result word |
| cy_o | output | 2 | Carry (add) or borrow (subtract) trit |
| hi_o | output | 2*N | High product word (multiply) |
| lt_o | output | 2 | X less than Y flag trit |
| eq_o | output | 2 | X equal to Y flag trit |
| gt_o | output | 2 | X greater than Y flag trit |
| err_o | output | 1 | Illegal trit code seen on an input |

## Verification
The bench walks all nine operations over all 81 operand pairs and checks each one against an integer model. This catches a select decode that is off by one digit, which would return the neighbouring operation. The largest cases matter most. 8+8 must give a carry of 1, 8·8 must give high word 7, and 0−8 must show a borrow: a subtractor that inverts the final carry would get these exactly backwards. Illegal codes are placed in each input field in turn, so an error flag that only watches one field, or that lets a stale result leak out, is exposed. The registered variant is checked one edge late and under reset, which catches a stage that passes inputs straight through.

// File: rtl/tern_alu_pkg.sv
package tern_alu_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T0 = 2'b00;
    localparam trit_t T1 = 2'b01;
    localparam trit_t T2 = 2'b10;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_CMP  = 4'd3,
        OP_NAND = 4'd4,
        OP_NOR  = 4'd5,
        OP_XOR  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_BAD  = 4'd15
    } op_e;

    function automatic trit_t t_min(input trit_t a, input trit_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic trit_t t_max(input trit_t a, input trit_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic trit_t t_not(input trit_t a);
        return T2 - a;
    endfunction

    function automatic trit_t t_xor(input trit_t a, input trit_t b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s >= 3'd3) ? trit_t'(s - 3'd3) : trit_t'(s);
    endfunction

endpackage

// File: rtl/tern_lit_dec.sv
module tern_lit_dec
    import tern_alu_pkg::*;
(
    input  trit_t       t_i,
    output logic [5:0]  lit_o
);
    for (genvar n = 0; n < 3; n++) begin : g_lit
        assign lit_o[2*n +: 2] = (t_i == trit_t'(n)) ? T2 : T0;
    end
endmodule

// File: rtl/tern_addsub.sv
module tern_addsub
    import tern_alu_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [2*N-1:0] x_i,
    input  logic [2*N-1:0] y_i,
    input  trit_t          mode_i,
    output logic [2*N-1:0] sum_o,
    output trit_t          cy_o
);
    logic  sub;
    trit_t yv;
    int    s;
    int    c;

    assign sub = (mode_i == T1);

    always_comb begin
        c     = sub ? 1 : 0;
        sum_o = '0;
        yv    = T0;
        s     = 0;
        for (int i = 0; i < N; i++) begin
            yv = sub ? t_not(y_i[2*i +: 2]) : y_i[2*i +: 2];
            s  = int'(x_i[2*i +: 2]) + int'(yv) + c;
            sum_o[2*i +: 2] = trit_t'(s % 3);
            c  = s / 3;
        end
        if (sub) cy_o = (c == 0) ? T1 : T0;
        else     cy_o = trit_t'(c);
    end
endmodule

// File: rtl/tern_mul.sv
module tern_mul
    import tern_alu_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [2*N-1:0] x_i,
    input  logic [2*N-1:0] y_i,
    output logic [2*N-1:0] lo_o,
    output logic [2*N-1:0] hi_o
);
    int xv;
    int yv;
    int p;

    always_comb begin
        xv = 0;
        yv = 0;
        for (int i = N - 1; i >= 0; i--) begin
            xv = xv * 3 + int'(x_i[2*i +: 2]);
            yv = yv * 3 + int'(y_i[2*i +: 2]);
        end
        p = xv * yv;
        for (int i = 0; i < N; i++) begin
            lo_o[2*i +: 2] = trit_t'(p % 3);
            p = p / 3;
        end
        for (int i = 0; i < N; i++) begin
            hi_o[2*i +: 2] = trit_t'(p % 3);
            p = p / 3;
        end
    end
endmodule

// File: rtl/tern_cmp.sv
module tern_cmp
    import tern_alu_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [2*N-1:0] x_i,
    input  logic [2*N-1:0] y_i,
    output trit_t          lt_o,
    output trit_t          eq_o,
    output trit_t          gt_o
);
    logic [N-1:0][1:0] teq;
    logic [N-1:0][1:0] tlt;
    logic [N-1:0][1:0] tgt;

    for (genvar g = 0; g < N; g++) begin : g_trit
        logic [5:0] xl;
        logic [5:0] yl;
        tern_lit_dec u_xd (.t_i(x_i[2*g +: 2]), .lit_o(xl));
        tern_lit_dec u_yd (.t_i(y_i[2*g +: 2]), .lit_o(yl));
        assign teq[g] = t_max(t_max(t_min(xl[1:0], yl[1:0]), t_min(xl[3:2], yl[3:2])),
                              t_min(xl[5:4], yl[5:4]));
        assign tlt[g] = t_max(t_min(xl[1:0], t_max(yl[3:2], yl[5:4])), t_min(xl[3:2], yl[5:4]));
        assign tgt[g] = t_max(t_min(yl[1:0], t_max(xl[3:2], xl[5:4])), t_min(yl[3:2], xl[5:4]));
    end

    always_comb begin
        lt_o = T0;
        gt_o = T0;
        eq_o = T2;
        for (int i = 0; i < N; i++) begin
            eq_o = t_min(eq_o, teq[i]);
            if (tlt[i] == T2) begin
                lt_o = T2;
                gt_o = T0;
            end else if (tgt[i] == T2) begin
                lt_o = T0;
                gt_o = T2;
            end
        end
    end
endmodule

// File: rtl/tern_alu.sv
module tern_alu
    import tern_alu_pkg::*;
#(
    parameter int N       = 2,
    parameter bit REG_OUT = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*N-1:0] x_i,
    input  logic [2*N-1:0] y_i,
    input  logic [3:0]     sel_i,
    output logic [2*N-1:0] res_o,
    output logic [1:0]     cy_o,
    output logic [2*N-1:0] hi_o,
    output logic [1:0]     lt_o,
    output logic [1:0]     eq_o,
    output logic [1:0]     gt_o,
    output logic           err_o
);
    localparam int W = 2 * N;

    typedef struct packed {
        logic         err;
        logic [W-1:0] res;
        trit_t        cy;
        logic [W-1:0] hi;
        trit_t        lt;
        trit_t        eq;
        trit_t        gt;
    } out_t;

    op_e          op;
    logic         bad_code;
    logic         err_c;
    logic         use_as;
    logic         use_mul;
    logic         use_cmp;
    trit_t        mode;
    logic [W-1:0] xa, ya, xm, ym, xc, yc;
    logic [W-1:0] as_sum, mul_lo, mul_hi, lg_res;
    trit_t        as_cy, c_lt, c_eq, c_gt;
    out_t         nxt;
    out_t         cur;

    // Operation decode: select code to operation state.
    always_comb begin
        unique case (sel_i)
            4'b0000: op = OP_ADD;
            4'b0001: op = OP_SUB;
            4'b0010: op = OP_MUL;
            4'b0100: op = OP_CMP;
            4'b0101: op = OP_NAND;
            4'b0110: op = OP_NOR;
            4'b1000: op = OP_XOR;
            4'b1001: op = OP_AND;
            4'b1010: op = OP_OR;
            default: op = OP_BAD;
        endcase
    end

    always_comb begin
        bad_code = 1'b0;
        for (int i = 0; i < N; i++) begin
            bad_code |= (x_i[2*i +: 2] == 2'b11) | (y_i[2*i +: 2] == 2'b11);
        end
    end
    assign err_c = bad_code | (op == OP_BAD);

    // Operand gating: only the selected unit sees the operands.
    assign use_as  = (op == OP_ADD) | (op == OP_SUB);
    assign use_mul = (op == OP_MUL);
    assign use_cmp = (op == OP_CMP);
    assign mode    = (op == OP_SUB) ? T1 : T2;
    assign xa = use_as  ? x_i : '0;
    assign ya = use_as  ? y_i : '0;
    assign xm = use_mul ? x_i : '0;
    assign ym = use_mul ? y_i : '0;
    assign xc = use_cmp ? x_i : '0;
    assign yc = use_cmp ? y_i : '0;

    tern_addsub #(.N(N)) u_as  (.x_i(xa), .y_i(ya), .mode_i(mode), .sum_o(as_sum), .cy_o(as_cy));
    tern_mul    #(.N(N)) u_mul (.x_i(xm), .y_i(ym), .lo_o(mul_lo), .hi_o(mul_hi));
    tern_cmp    #(.N(N)) u_cmp (.x_i(xc), .y_i(yc), .lt_o(c_lt), .eq_o(c_eq), .gt_o(c_gt));

    // Trit-wise logic functions.
    for (genvar g = 0; g < N; g++) begin : g_logic
        trit_t a, b;
        assign a = x_i[2*g +: 2];
        assign b = y_i[2*g +: 2];
        always_comb begin
            unique case (op)
                OP_NAND: lg_res[2*g +: 2] = t_not(t_min(a, b));
                OP_NOR:  lg_res[2*g +: 2] = t_not(t_max(a, b));
                OP_XOR:  lg_res[2*g +: 2] = t_xor(a, b);
                OP_AND:  lg_res[2*g +: 2] = t_min(a, b);
                OP_OR:   lg_res[2*g +: 2] = t_max(a, b);
                default: lg_res[2*g +: 2] = T0;
            endcase
        end
    end

    // Output state: assemble the selected result.
    always_comb begin
        nxt = '0;
        if (err_c) begin
            nxt.err = 1'b1;
        end else begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    nxt.res = as_sum;
                    nxt.cy  = as_cy;
                end
                OP_MUL: begin
                    nxt.res = mul_lo;
                    nxt.hi  = mul_hi;
                end
                OP_CMP: begin
                    nxt.lt = c_lt;
                    nxt.eq = c_eq;
                    nxt.gt = c_gt;
                end
                default: nxt.res = lg_res;
            endcase
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur <= '0;
            else        cur <= nxt;
        end
    end else begin : g_comb
        assign cur = nxt;
    end

    assign err_o = cur.err;
    assign res_o = cur.res;
    assign cy_o  = cur.cy;
    assign hi_o  = cur.hi;
    assign lt_o  = cur.lt;
    assign eq_o  = cur.eq;
    assign gt_o  = cur.gt;
endmodule

// File: rtl/tern_alu_chk.sv
module tern_alu_chk #(
    parameter int N       = 2,
    parameter bit REG_OUT = 1'b0
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     sel_i,
    input logic [2*N-1:0] res_o,
    input logic [1:0]     cy_o,
    input logic [2*N-1:0] hi_o,
    input logic [1:0]     lt_o,
    input logic [1:0]     eq_o,
    input logic [1:0]     gt_o,
    input logic           err_o
);
    logic res_bad;
    always_comb begin
        res_bad = 1'b0;
        for (int i = 0; i < N; i++) res_bad |= (res_o[2*i +: 2] == 2'b11);
    end

    // R1
    res_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) !res_bad);

    // R3
    cy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_o == 2'b00) || (cy_o == 2'b01));

    // R5
    flag_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lt_o == 2'b10, eq_o == 2'b10, gt_o == 2'b10}) <= 1);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (res_o == '0 && cy_o == '0 && hi_o == '0 &&
                   lt_o == '0 && eq_o == '0 && gt_o == '0));

    if (!REG_OUT) begin : g_comb_chk
        // R9
        logic_aux_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i[3:2] != 2'b00) |-> (cy_o == '0 && hi_o == '0));
    end
endmodule

bind tern_alu tern_alu_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .res_o(res_o), .cy_o(cy_o),
    .hi_o(hi_o), .lt_o(lt_o), .eq_o(eq_o), .gt_o(gt_o), .err_o(err_o)
);

// File: tb/tern_alu_tb_top.sv
module tern_alu_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] x, y, sel;
    logic [3:0] res_a, hi_a, res_b, hi_b;
    logic [1:0] cy_a, lt_a, eq_a, gt_a, cy_b, lt_b, eq_b, gt_b;
    logic       err_a, err_b;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tern_alu #(.N(2), .REG_OUT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .sel_i(sel),
        .res_o(res_a), .cy_o(cy_a), .hi_o(hi_a), .lt_o(lt_a), .eq_o(eq_a),
        .gt_o(gt_a), .err_o(err_a));

    tern_alu #(.N(2), .REG_OUT(1'b1)) dut_reg_i (
        .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .sel_i(sel),
        .res_o(res_b), .cy_o(cy_b), .hi_o(hi_b), .lt_o(lt_b), .eq_o(eq_b),
        .gt_o(gt_b), .err_o(err_b));

    function automatic logic [3:0] enc(input int v);
        return {2'(v / 3), 2'(v % 3)};
    endfunction

    // Pack: {err, res[3:0], cy[1:0], hi[3:0], lt, eq, gt}
    function automatic logic [16:0] model(input int xv, input int yv, input int op);
        logic [3:0] r, h;
        logic [1:0] c, l, e, g;
        int a, b;
        r = '0; h = '0; c = '0; l = '0; e = '0; g = '0;
        case (op)
            0: begin r = enc((xv + yv) % 9); c = 2'((xv + yv) / 9); end
            1: begin r = enc((xv - yv + 9) % 9); c = (xv < yv) ? 2'd1 : 2'd0; end
            2: begin r = enc((xv * yv) % 9); h = enc((xv * yv) / 9); end
            3: begin
                l = (xv < yv) ? 2'd2 : 2'd0;
                e = (xv == yv) ? 2'd2 : 2'd0;
                g = (xv > yv) ? 2'd2 : 2'd0;
            end
            default: begin
                for (int k = 0; k < 2; k++) begin
                    int d;
                    a = (k == 0) ? xv % 3 : xv / 3;
                    b = (k == 0) ? yv % 3 : yv / 3;
                    case (op)
                        4: d = 2 - ((a < b) ? a : b);
                        5: d = 2 - ((a > b) ? a : b);
                        6: d = (a + b) % 3;
                        7: d = (a < b) ? a : b;
                        default: d = (a > b) ? a : b;
                    endcase
                    r[2*k +: 2] = 2'(d);
                end
            end
        endcase
        return {1'b0, r, c, h, l, e, g};
    endfunction

    function automatic logic [16:0] pack_a();
        return {err_a, res_a, cy_a, hi_a, lt_a, eq_a, gt_a};
    endfunction

    function automatic logic [16:0] pack_b();
        return {err_b, res_b, cy_b, hi_b, lt_b, eq_b, gt_b};
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s x=%h y=%h sel=%h actual=%h expected=%h", req, x, y, sel, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] xv, input logic [3:0] yv, input logic [3:0] sv);
        @(negedge clk);
        x = xv; y = yv; sel = sv;
        #(CLK_P/4);
    endtask

    // R11: registered outputs are zero while reset is held
    task automatic t_reset();
        x = enc(8); y = enc(8); sel = enc(2);
        #(CLK_P*2);
        check("R11 reset", pack_b(), 17'h0);
    endtask

    // R1 R2 R3 R4: arithmetic over every operand pair
    task automatic t_arith();
        for (int op = 0; op < 3; op++)
            for (int xv = 0; xv < 9; xv++)
                for (int yv = 0; yv < 9; yv++) begin
                    apply(enc(xv), enc(yv), enc(op));
                    check(op == 0 ? "R2 add" : (op == 1 ? "R3 sub" : "R4 mul"),
                          pack_a(), model(xv, yv, op));
                end
    endtask

    // R5 R9: comparison flags
    task automatic t_compare();
        for (int xv = 0; xv < 9; xv++)
            for (int yv = 0; yv < 9; yv++) begin
                apply(enc(xv), enc(yv), enc(3));
                check("R5 cmp", pack_a(), model(xv, yv, 3));
            end
    endtask

    // R6 R7 R8 R9: trit-wise logic
    task automatic t_logic();
        for (int op = 4; op < 9; op++)
            for (int xv = 0; xv < 9; xv++)
                for (int yv = 0; yv < 9; yv++) begin
                    apply(enc(xv), enc(yv), enc(op));
                    check(op < 6 ? "R7 nand/nor" : (op == 6 ? "R8 xor" : "R6 and/or"),
                          pack_a(), model(xv, yv, op));
                end
    endtask

    // R10: illegal trit in each field
    task automatic t_illegal();
        apply(4'b1100, enc(4), enc(0)); check("R10 x hi", pack_a(), 17'h10000);
        apply(4'b0011, enc(4), enc(2)); check("R10 x lo", pack_a(), 17'h10000);
        apply(enc(5), 4'b1101, enc(3)); check("R10 y hi", pack_a(), 17'h10000);
        apply(enc(5), 4'b0111, enc(7)); check("R10 y lo", pack_a(), 17'h10000);
        apply(enc(8), enc(8), 4'b0011); check("R10 sel lo", pack_a(), 17'h10000);
        apply(enc(8), enc(8), 4'b1110); check("R10 sel hi", pack_a(), 17'h10000);
        apply(enc(8), enc(1), enc(0));  check("R10 recover", pack_a(), model(8, 1, 0));
    endtask

    // R11: registered variant lags one rising edge
    task automatic t_registered();
        apply(enc(8), enc(8), enc(2));
        @(posedge clk); #1;
        check("R11 capture", pack_b(), model(8, 8, 2));
        @(negedge clk);
        x = enc(0); y = enc(8); sel = enc(1);
        #1;
        check("R11 hold", pack_b(), model(8, 8, 2));
        @(posedge clk); #1;
        check("R11 next", pack_b(), model(0, 8, 1));
        rst_n = 1'b0; #1;
        check("R11 async reset", pack_b(), 17'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_arith();
        t_compare();
        t_logic();
        t_illegal();
        t_registered();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule